// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

The block moves a fixed-length run of 32-bit words from a streaming source into memory. A `start` pulse makes it pop one base byte offset from an offset FIFO. It clears the two low bits of that offset, which gives a word-aligned start address. It then writes the run to consecutive addresses through an AXI4 write master and signals completion only once memory has acknowledged every burst. The words are opaque bit patterns, and the block never changes their contents.

Both inputs use a first-word-fall-through FIFO handshake. The head entry is valid whenever `*_empty` is low, and the entry is consumed on a clock edge where the block holds `*_rd` high. The run is longer than one AXI4 burst can carry, so it is cut into bursts of at most `MAX_BURST` beats. With the default sizes this gives one burst of 256 beats and a tail burst of 68 beats. Each burst's address phase is issued before its data. A data word leaves the data FIFO only on the same cycle that the write channel accepts it. When neither side stalls, one word moves per clock.

Top module: `stream_burst_writer`

## Requirements
- R1: While `rst` is high (synchronous, active-high) and on the first cycle after it, `awvalid`, `wvalid`, `bready`, `done`, `off_rd` and `dat_rd` are all low.
- R2: Each `start` received while idle causes exactly one offset pop (`off_rd` high with `off_empty` low). This pop happens before the first address handshake. No offset is popped while idle without `start`.
- R3: The first burst address equals the popped offset with bits [1:0] forced to zero.
- R4: The run of `WORD_COUNT` words is issued as bursts of `MAX_BURST` beats followed by one remainder burst (defaults: `awlen` 255 at base, then `awlen` 67 at base+1024). Every burst carries `awsize`=3'b010 and `awburst`=2'b01 (incrementing). Address and length hold steady while `awvalid` waits for `awready`.
- R5: Exactly `WORD_COUNT` beats are written, carrying the data FIFO words in pop order, none lost or repeated under any mix of FIFO-empty and `wready` stalls. Every beat has `wstrb`=4'b1111.
- R6: `wlast` is high on the final beat of every burst and on no other beat.
- R7: `done` is a one-cycle pulse that occurs only after the write responses of all bursts have been accepted.
- R8: A response with `bresp` other than 2'b00 sets `err`. `err` remains set through `done` and while idle afterwards, and it is cleared by the next accepted `start`.
- R9: With the data FIFO never empty and `wready` always high, the beats of one burst occupy consecutive clock cycles (256 beats span 255 cycles from first to last).
- R10: A `start` pulse while a run is in progress is ignored. The offset FIFO is not popped again until the run has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag: a non-OKAY write response was seen |
| off_data | input | ADDR_W | Head of offset FIFO (byte offset) |
| off_empty | input | 1 | Offset FIFO empty |
| off_rd | output | 1 | Pop offset FIFO |
| dat_data | input | DATA_W | Head of data FIFO |
| dat_empty | input | 1 | Data FIFO empty |
| dat_rd | output | 1 | Pop data FIFO |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats in burst minus one |
| awsize | output | 3 | Beat size code (4 bytes) |
| awburst | output | 2 | Burst type (incrementing) |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address accepted |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat of burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response accepted |

## Verification
The bench builds the block with its default sizes: 324 words split at 256 beats. This makes the full-length 256-beat burst, the wrap of the 8-bit beat counter at its last beat, and the 68-beat remainder all occur in every run. Runs with random stalls on the address channel, write channel, data FIFO and response channel check that backpressure neither drops nor repeats a word. A stall-free run checks the one-word-per-cycle rate. Error responses on either burst, and a clean run afterwards, check that the error flag is sticky and is cleared by the next start.

// File: rtl/stream_burst_writer.sv
module stream_burst_writer #(
  parameter int WORD_COUNT = 324,
  parameter int MAX_BURST  = 256,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                done,
  output logic                err,
  input  logic [ADDR_W-1:0]   off_data,
  input  logic                off_empty,
  output logic                off_rd,
  input  logic [DATA_W-1:0]   dat_data,
  input  logic                dat_empty,
  output logic                dat_rd,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready
);
  localparam int BYTES      = DATA_W / 8;
  localparam int LSB        = $clog2(BYTES);
  localparam int CNT_W      = $clog2(WORD_COUNT + 1);
  localparam int NUM_BURSTS = (WORD_COUNT + MAX_BURST - 1) / MAX_BURST;
  localparam int BCNT_W     = $clog2(NUM_BURSTS + 1);

  typedef enum logic [2:0] {S_IDLE, S_OFF, S_AW, S_W, S_RESP, S_DONE} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   base;
  logic [CNT_W-1:0]    word_cnt;
  logic [CNT_W-1:0]    remain;
  logic [7:0]          beat;
  logic [7:0]          len_q;
  logic [7:0]          next_len;
  logic [BCNT_W-1:0]   aw_cnt;
  logic [BCNT_W-1:0]   b_cnt;
  logic                b_take;
  logic                last_word;
  logic                resp_all;

  assign remain    = CNT_W'(WORD_COUNT) - word_cnt;
  assign next_len  = (int'(remain) > MAX_BURST) ? 8'(MAX_BURST - 1) : 8'(remain - 1'b1);
  assign last_word = (word_cnt == CNT_W'(WORD_COUNT - 1));
  assign b_take    = bvalid && bready;
  assign resp_all  = (b_cnt == aw_cnt) || (b_take && (b_cnt + 1'b1 == aw_cnt));

  assign off_rd  = (state == S_OFF) && !off_empty;

  assign awvalid = (state == S_AW);
  assign awaddr  = base + (ADDR_W'(word_cnt) << LSB);
  assign awlen   = next_len;
  assign awsize  = 3'(LSB);
  assign awburst = 2'b01;

  assign wvalid  = (state == S_W) && !dat_empty;
  assign wdata   = dat_data;
  assign wstrb   = '1;
  assign wlast   = (beat == len_q);
  assign dat_rd  = wvalid && wready;

  assign bready  = (aw_cnt != b_cnt);
  assign done    = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      base     <= '0;
      word_cnt <= '0;
      beat     <= '0;
      len_q    <= '0;
      aw_cnt   <= '0;
      b_cnt    <= '0;
      err      <= 1'b0;
    end else begin
      if (b_take) begin
        b_cnt <= b_cnt + 1'b1;
        if (bresp != 2'b00) err <= 1'b1;
      end
      unique case (state)
        S_IDLE: if (start) begin
          state    <= S_OFF;
          word_cnt <= '0;
          aw_cnt   <= '0;
          b_cnt    <= '0;
          err      <= 1'b0;
        end
        S_OFF: if (off_rd) begin
          base  <= off_data & ~ADDR_W'(BYTES - 1);
          state <= S_AW;
        end
        S_AW: if (awready) begin
          len_q  <= next_len;
          beat   <= '0;
          aw_cnt <= aw_cnt + 1'b1;
          state  <= S_W;
        end
        S_W: if (dat_rd) begin
          word_cnt <= word_cnt + 1'b1;
          beat     <= beat + 1'b1;
          if (wlast) state <= last_word ? S_RESP : S_AW;
        end
        S_RESP: if (resp_all) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OFF_BEFORE_BUS: assert property (@(posedge clk) disable iff (rst)
    off_rd |-> !awvalid && !wvalid && (aw_cnt == '0)); // R2

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen)); // R4

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    word_cnt <= CNT_W'(WORD_COUNT)); // R5

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    wvalid && wready && wlast |=> !wvalid); // R6

  AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (rst)
    done |-> (b_cnt == aw_cnt) && (aw_cnt == BCNT_W'(NUM_BURSTS))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == S_W) && start |=> (state != S_OFF)); // R10
endmodule

// File: tb/stream_burst_writer_bench.sv
module stream_burst_writer_bench;
  localparam int WORDS = 324;
  localparam int MAXB  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        done, err;
  logic [31:0] off_data = '0;
  logic        off_empty = 1'b1;
  logic        off_rd;
  logic [31:0] dat_data = '0;
  logic        dat_empty = 1'b1;
  logic        dat_rd;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        awvalid;
  logic        awready = 1'b0;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        wlast, wvalid;
  logic        wready = 1'b0;
  logic [1:0]  bresp = 2'b00;
  logic        bvalid = 1'b0;
  logic        bready;

  stream_burst_writer u_stream_burst_writer (
    .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
    .off_data(off_data), .off_empty(off_empty), .off_rd(off_rd),
    .dat_data(dat_data), .dat_empty(dat_empty), .dat_rd(dat_rd),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ 32'(i << 7);
  endfunction

  int aw_stall = 0, w_stall = 0, e_stall = 0, b_stall = 0;
  int bad_burst = -1;
  bit run_on = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] exp_base;
  int idx = 0;
  bit pop_pend = 1'b0, off_pop = 1'b0, b_take = 1'b0;
  int b_pending = 0, b_sent = 0, b_acc = 0;
  int off_reads = 0, aw_seen = 0, beats = 0, beat_in = 0, cur_len = 0;
  int wlast_seen = 0, done_seen = 0, cyc = 0;
  int first_cyc = 0, b1_last_cyc = 0;
  bit err_at_done = 1'b0;

  // driver: FIFO and slave models; pushes expected words as they are popped
  always @(negedge clk) begin
    cyc++;
    if (pop_pend) idx++;
    dat_data = word_of(idx);
    if (off_pop) off_empty = 1'b1;
    if (b_take) begin
      b_pending--;
      b_sent++;
      b_acc++;
      bvalid = 1'b0;
    end
    if (run_on) begin
      dat_empty = ($urandom % 100) < e_stall;
      wready    = ($urandom % 100) >= w_stall;
      awready   = ($urandom % 100) >= aw_stall;
      if (!bvalid && b_pending > 0 && ($urandom % 100) >= b_stall) bvalid = 1'b1;
      bresp = (bvalid && b_sent == bad_burst) ? 2'b10 : 2'b00;
    end else begin
      dat_empty = 1'b1; wready = 1'b0; awready = 1'b0;
    end
    #1;
    pop_pend = dat_rd && !rst;
    if (pop_pend) exp_q.push_back(dat_data);
    off_pop = off_rd && !rst;
    if (off_pop) off_reads++;
    b_take = bvalid && bready && !rst;
  end

  // monitor: pops expected words and compares bus traffic
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (awvalid && awready) begin
        chk(awaddr == exp_base + 32'(aw_seen * MAXB * 4), aw_seen == 0 ? "R3 first address" : "R4 burst address",
            awaddr, exp_base + 32'(aw_seen * MAXB * 4));
        chk(int'(awlen) == ((WORDS - aw_seen * MAXB > MAXB) ? MAXB - 1 : WORDS - aw_seen * MAXB - 1),
            "R4 burst length", awlen, (WORDS - aw_seen * MAXB > MAXB) ? MAXB - 1 : WORDS - aw_seen * MAXB - 1);
        chk(awsize == 3'b010 && awburst == 2'b01, "R4 size/type", {awsize, awburst}, {3'b010, 2'b01});
        chk(off_reads == 1, "R2 offset popped before address", off_reads, 1);
        cur_len = int'(awlen);
        beat_in = 0;
        aw_seen++;
      end
      if (wvalid && wready) begin
        beats++;
        if (exp_q.size() == 0) chk(1'b0, "R5 beat without popped word", wdata, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(wdata == e, "R5 data order", wdata, e);
        end
        chk(wstrb == 4'hF, "R5 strobes", wstrb, 4'hF);
        chk(wlast == (beat_in == cur_len), "R6 last marker", wlast, beat_in == cur_len);
        if (beats == 1) first_cyc = cyc;
        if (beats == MAXB) b1_last_cyc = cyc;
        if (wlast) begin
          wlast_seen++;
          b_pending++;
        end
        beat_in++;
      end
      if (done) begin
        done_seen++;
        err_at_done = err;
        chk(b_acc == 2, "R7 done after all responses", b_acc, 2);
        chk(beats == WORDS, "R5 beat count at done", beats, WORDS);
      end
    end
  end

  task automatic run_case(string name, logic [31:0] off, int aws, int ws, int es, int bs,
                          int bad, bit poke, bit rate);
    bit poked = 1'b0;
    bit finished = 1'b0;
    @(negedge clk);
    off_reads = 0; aw_seen = 0; beats = 0; wlast_seen = 0; done_seen = 0;
    b_acc = 0; b_sent = 0; b_pending = 0; exp_q.delete();
    aw_stall = aws; w_stall = ws; e_stall = es; b_stall = bs; bad_burst = bad;
    exp_base = off & 32'hFFFF_FFFC;
    off_data = off; off_empty = 1'b0; start = 1'b1; run_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (poke && poked) start = 1'b0;
      #3;
      if (poke && !poked && aw_seen == 1) begin
        poked = 1'b1;
        @(negedge clk);
        off_data = 32'h0BAD_0000; off_empty = 1'b0; start = 1'b1;
      end
      if (done_seen > 0) begin
        finished = 1'b1;
        break;
      end
    end
    start = 1'b0;
    if (!finished) chk(1'b0, {"R7 run never completed: ", name}, 0, 1);
    repeat (3) @(negedge clk);
    #3;
    chk(off_reads == 1, "R2 one offset pop per run", off_reads, 1);
    chk(aw_seen == 2, "R4 burst count", aw_seen, 2);
    chk(beats == WORDS, "R5 total beats", beats, WORDS);
    chk(exp_q.size() == 0, "R5 no popped word left unsent", exp_q.size(), 0);
    chk(wlast_seen == 2, "R6 last markers", wlast_seen, 2);
    chk(done_seen == 1, "R7 done pulse width", done_seen, 1);
    chk(err_at_done == (bad >= 0), "R8 error flag at done", err_at_done, bad >= 0);
    chk(err == (bad >= 0), "R8 error flag sticky when idle", err, bad >= 0);
    if (rate) chk(b1_last_cyc - first_cyc == MAXB - 1, "R9 one beat per cycle", b1_last_cyc - first_cyc, MAXB - 1);
    if (poke) begin
      chk(!off_empty, "R10 offset token untouched while busy", off_empty, 0);
      @(negedge clk);
      off_empty = 1'b1;
    end
    run_on = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    off_empty = 1'b0;
    off_data = 32'h1234_5678;
    repeat (3) @(negedge clk);
    #3;
    chk(!awvalid && !wvalid && !bready && !done && !off_rd && !dat_rd, "R1 outputs during reset",
        {awvalid, wvalid, bready, done, off_rd, dat_rd}, 0);
    @(negedge clk);
    rst = 1'b0;
    #3;
    chk(!awvalid && !wvalid && !bready && !done && !off_rd && !dat_rd, "R1 outputs after reset",
        {awvalid, wvalid, bready, done, off_rd, dat_rd}, 0);
    repeat (4) @(negedge clk);
    #3;
    chk(off_reads == 0 && !off_rd, "R2 no pop while idle without start", off_reads, 0);
    @(negedge clk);
    off_empty = 1'b1;

    run_case("clean",        32'h0000_1000, 0,  0,  0,  0, -1, 1'b0, 1'b1);
    run_case("unaligned",    32'h0000_2467, 30, 30, 30, 30, -1, 1'b0, 1'b0);
    run_case("bad second",   32'h8000_0003, 10, 50, 20, 60, 1, 1'b0, 1'b0);
    run_case("clear err",    32'h0000_0000, 0,  0,  0,  0, -1, 1'b0, 1'b1);
    run_case("bad first",    32'hFFFF_0001, 70, 10, 60, 10, 0, 1'b0, 1'b0);
    run_case("busy start",   32'h0040_0802, 20, 20, 20, 20, -1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule